// File: doc/BRIEF.md
# SPI Transfer Request Gate

This block screens one SPI transfer request header at a time against a fixed capability record describing what the SPI controller behind it can do. It accepts a header through a valid/ready handshake. One cycle later it returns a registered result code that says whether the transfer may proceed or must be refused as a parameter error.

The capability record is presented as static inputs. These are:
- the number of chip selects;
- whether chip select may toggle between transfers;
- separate multi-lane support masks for transmit and receive;
- a word-size mask;
- a mode support word;
- a frequency ceiling;
- four delay ceilings: between words, chip-select setup, chip-select hold, and chip-select inactive time.

Every field of the header is tested against these. Any single violation refuses the request. The code reserved for a failure during the transfer itself is never produced here, because no transfer is performed.

Top module: `spi_xfer_gate`

## Requirements
- R1: `req_ready` is low while `rst_n` is low, rises on the first clock edge after reset is released, and then stays high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `res_valid` is high for exactly the cycle after each accepted request and low otherwise. Back-to-back requests each receive their own result.
- R2: `res_code` is 0 when every check passes and 1 when any check fails. The value 2, meaning a transfer failure, is never produced.
- R3: a chip-select index greater than or equal to `cap_cs_count` is a parameter error.
- R4: a word size of 0 or above 32 is an error. If `cap_bpw_mask` is nonzero, a word size of n bits additionally requires mask bit n-1 to be set. An all-zero mask places no restriction.
- R5: a nonzero `req_cs_change` is an error when `cap_cs_toggle_off` is 1. When `cap_cs_toggle_off` is 0, any `req_cs_change` value is allowed.
- R6: each lane-count field accepts 0 or 1 (single lane) in all cases. It accepts 2 only if lane-mask bit 0 is set, 4 only if bit 1 is set, and 8 only if bit 2 is set. Any other value is an error. Transmit is judged against `cap_tx_lanes` and receive against `cap_rx_lanes`.
- R7: clock phase is request mode bit 0 and clock polarity is request mode bit 1. Capability bits 1:0 govern phase and bits 3:2 govern polarity. In each of these fields, 00 allows both values, 01 allows only 0, and 10 allows only 1.
- R8: active-high chip select is request mode bit 2 and needs capability bit 4. LSB-first is request mode bit 3 and needs capability bit 5. Loopback is request mode bit 4 and needs capability bit 6.
- R9: a requested frequency above a nonzero `cap_max_freq` is an error. A `cap_max_freq` of 0 means no limit.
- R10: for the word, setup, hold and inactive delays, a requested value above its ceiling is an error. A ceiling of 0 therefore rejects any nonzero request for that delay.
- R11: if either capability field at bits 1:0 or bits 3:2 holds the invalid value 11, every request is refused.
- R12: during and directly after reset, `res_valid` and `res_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_cs_count | input | 8 | Number of chip selects available |
| cap_cs_toggle_off | input | 1 | 1 = chip select cannot toggle between transfers |
| cap_tx_lanes | input | 3 | Transmit lane support: bit0 dual, bit1 quad, bit2 octal |
| cap_rx_lanes | input | 3 | Receive lane support: bit0 dual, bit1 quad, bit2 octal |
| cap_bpw_mask | input | 32 | Supported word sizes, bit n-1 for n bits; 0 = any |
| cap_mode_sup | input | 7 | Phase field, polarity field, active-high, LSB-first, loopback support |
| cap_max_freq | input | 32 | Frequency ceiling, 0 = unlimited |
| cap_max_word_dly | input | 32 | Inter-word delay ceiling, 0 = unsupported |
| cap_max_setup | input | 32 | Chip-select setup delay ceiling, 0 = unsupported |
| cap_max_hold | input | 32 | Chip-select hold delay ceiling, 0 = unsupported |
| cap_max_inact | input | 32 | Chip-select inactive delay ceiling, 0 = unsupported |
| req_valid | input | 1 | Request header present |
| req_ready | output | 1 | Gate can take a request |
| req_cs | input | 8 | Chip-select index |
| req_bpw | input | 8 | Bits per word |
| req_cs_change | input | 8 | Nonzero = toggle chip select after transfer |
| req_tx_lanes | input | 8 | Transmit lane count |
| req_rx_lanes | input | 8 | Receive lane count |
| req_mode | input | 5 | Phase, polarity, active-high, LSB-first, loopback |
| req_freq | input | 32 | Requested clock rate |
| req_word_dly | input | 32 | Requested inter-word delay |
| req_setup | input | 32 | Requested setup delay |
| req_hold | input | 32 | Requested hold delay |
| req_inact | input | 32 | Requested inactive delay |
| res_valid | output | 1 | Result present, one cycle |
| res_code | output | 2 | 0 = accepted, 1 = parameter error |

## Verification
The only state is the ready flag and the registered result pair. A fault in either shows at the ports on the cycle right after a handshake: a missing or extra `res_valid` pulse, or a wrong code.

Each check is driven from a permissive baseline header with one field pushed across its boundary. A wrongly decoded field therefore shows up as a flipped code on that request's own result. Back-to-back requests with different outcomes expose any result that lags by a cycle.

// File: rtl/spi_gate_pkg.sv
package spi_gate_pkg;

    localparam int FIELD_W    = 8;
    localparam int WORD_W     = 32;
    localparam int LANE_SEL_W = 3;
    localparam int MAX_BPW    = 32;
    localparam int CAP_MODE_W = 7;
    localparam int REQ_MODE_W = 5;
    localparam int N_LIMITS   = 5;

    // request mode bit positions
    localparam int RM_PHASE  = 0;
    localparam int RM_POL    = 1;
    localparam int RM_CSHIGH = 2;
    localparam int RM_LSB    = 3;
    localparam int RM_LOOP   = 4;

    // capability mode bit positions
    localparam int CM_PHASE_LO = 0;
    localparam int CM_POL_LO   = 2;
    localparam int CM_CSHIGH   = 4;
    localparam int CM_LSB      = 5;
    localparam int CM_LOOP     = 6;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_PARAM_ERR = 2'd1,
        RES_XFER_ERR  = 2'd2
    } res_code_e;

    typedef struct packed {
        logic      ready;
        logic      res_valid;
        res_code_e res_code;
    } gate_state_t;

endpackage

// File: rtl/spi_gate_lane_chk.sv
module spi_gate_lane_chk #(
    parameter int FIELD_W = 8,
    parameter int MASK_W  = 3
) (
    input  logic [FIELD_W-1:0] lanes,
    input  logic [MASK_W-1:0]  sup_mask,
    output logic               fault
);

    always_comb begin
        fault = 1'b1;
        if (lanes <= FIELD_W'(1)) begin
            fault = 1'b0;
        end
        for (int k = 0; k < MASK_W; k++) begin
            if (lanes == FIELD_W'(32'd2 << k)) begin
                fault = !sup_mask[k];
            end
        end
    end

endmodule

// File: rtl/spi_gate_mode_chk.sv
module spi_gate_mode_chk
    import spi_gate_pkg::*;
(
    input  logic [CAP_MODE_W-1:0] cap_mode,
    input  logic [REQ_MODE_W-1:0] req_mode,
    output logic                  cap_broken,
    output logic                  fault
);

    logic [1:0] phase_sup;
    logic [1:0] pol_sup;
    logic       phase_bad;
    logic       pol_bad;
    logic       feat_bad;

    assign phase_sup = cap_mode[CM_PHASE_LO +: 2];
    assign pol_sup   = cap_mode[CM_POL_LO +: 2];

    // 00 both, 01 only zero, 10 only one, 11 invalid capability
    function automatic logic excl_bad(input logic [1:0] sup, input logic want);
        case (sup)
            2'b01:   excl_bad = want;
            2'b10:   excl_bad = !want;
            2'b11:   excl_bad = 1'b1;
            default: excl_bad = 1'b0;
        endcase
    endfunction

    always_comb begin
        cap_broken = (phase_sup == 2'b11) || (pol_sup == 2'b11);
        phase_bad  = excl_bad(phase_sup, req_mode[RM_PHASE]);
        pol_bad    = excl_bad(pol_sup, req_mode[RM_POL]);
        feat_bad   = (req_mode[RM_CSHIGH] && !cap_mode[CM_CSHIGH])
                  || (req_mode[RM_LSB]    && !cap_mode[CM_LSB])
                  || (req_mode[RM_LOOP]   && !cap_mode[CM_LOOP]);
        fault      = cap_broken || phase_bad || pol_bad || feat_bad;
    end

endmodule

// File: rtl/spi_gate_limit_chk.sv
module spi_gate_limit_chk #(
    parameter int  W              = 32,
    parameter bit  ZERO_UNLIMITED = 1'b0
) (
    input  logic [W-1:0] ceiling,
    input  logic [W-1:0] request,
    output logic         fault
);

    generate
        if (ZERO_UNLIMITED) begin : g_open
            assign fault = (ceiling != '0) && (request > ceiling);
        end else begin : g_closed
            // a zero ceiling rejects any nonzero request
            assign fault = request > ceiling;
        end
    endgenerate

endmodule

// File: rtl/spi_xfer_gate.sv
module spi_xfer_gate
    import spi_gate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIELD_W-1:0]    cap_cs_count,
    input  logic                  cap_cs_toggle_off,
    input  logic [LANE_SEL_W-1:0] cap_tx_lanes,
    input  logic [LANE_SEL_W-1:0] cap_rx_lanes,
    input  logic [WORD_W-1:0]     cap_bpw_mask,
    input  logic [CAP_MODE_W-1:0] cap_mode_sup,
    input  logic [WORD_W-1:0]     cap_max_freq,
    input  logic [WORD_W-1:0]     cap_max_word_dly,
    input  logic [WORD_W-1:0]     cap_max_setup,
    input  logic [WORD_W-1:0]     cap_max_hold,
    input  logic [WORD_W-1:0]     cap_max_inact,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [FIELD_W-1:0]    req_cs,
    input  logic [FIELD_W-1:0]    req_bpw,
    input  logic [FIELD_W-1:0]    req_cs_change,
    input  logic [FIELD_W-1:0]    req_tx_lanes,
    input  logic [FIELD_W-1:0]    req_rx_lanes,
    input  logic [REQ_MODE_W-1:0] req_mode,
    input  logic [WORD_W-1:0]     req_freq,
    input  logic [WORD_W-1:0]     req_word_dly,
    input  logic [WORD_W-1:0]     req_setup,
    input  logic [WORD_W-1:0]     req_hold,
    input  logic [WORD_W-1:0]     req_inact,
    output logic                  res_valid,
    output logic [1:0]            res_code
);

    gate_state_t st_d, st_q;

    logic cs_bad, bpw_bad, toggle_bad;
    logic tx_bad, rx_bad, mode_bad, cap_broken;
    logic any_bad;
    logic [WORD_W-1:0]   bpw_sel;
    logic [WORD_W-1:0]   lim_ceil [N_LIMITS];
    logic [WORD_W-1:0]   lim_req  [N_LIMITS];
    logic [N_LIMITS-1:0] lim_bad;

    // lanes, transmit then receive
    spi_gate_lane_chk #(.FIELD_W(FIELD_W), .MASK_W(LANE_SEL_W)) u_tx_lane (
        .lanes    (req_tx_lanes),
        .sup_mask (cap_tx_lanes),
        .fault    (tx_bad)
    );

    spi_gate_lane_chk #(.FIELD_W(FIELD_W), .MASK_W(LANE_SEL_W)) u_rx_lane (
        .lanes    (req_rx_lanes),
        .sup_mask (cap_rx_lanes),
        .fault    (rx_bad)
    );

    spi_gate_mode_chk u_mode (
        .cap_mode   (cap_mode_sup),
        .req_mode   (req_mode),
        .cap_broken (cap_broken),
        .fault      (mode_bad)
    );

    // slot 0 is the frequency (zero = unlimited), the rest are delays
    assign lim_ceil[0] = cap_max_freq;     assign lim_req[0] = req_freq;
    assign lim_ceil[1] = cap_max_word_dly; assign lim_req[1] = req_word_dly;
    assign lim_ceil[2] = cap_max_setup;    assign lim_req[2] = req_setup;
    assign lim_ceil[3] = cap_max_hold;     assign lim_req[3] = req_hold;
    assign lim_ceil[4] = cap_max_inact;    assign lim_req[4] = req_inact;

    generate
        for (genvar g = 0; g < N_LIMITS; g++) begin : g_lim
            spi_gate_limit_chk #(.W(WORD_W), .ZERO_UNLIMITED(g == 0)) u_lim (
                .ceiling (lim_ceil[g]),
                .request (lim_req[g]),
                .fault   (lim_bad[g])
            );
        end
    endgenerate

    always_comb begin
        cs_bad     = req_cs >= cap_cs_count;
        toggle_bad = cap_cs_toggle_off && (req_cs_change != '0);
        bpw_sel    = cap_bpw_mask >> (WORD_W'(req_bpw) - WORD_W'(1));
        bpw_bad    = (req_bpw == '0) || (req_bpw > FIELD_W'(MAX_BPW))
                  || ((cap_bpw_mask != '0) && !bpw_sel[0]);
        any_bad    = cs_bad || bpw_bad || toggle_bad || tx_bad || rx_bad
                  || mode_bad || cap_broken || (|lim_bad);

        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.res_valid = req_valid && st_q.ready;
        if (req_valid && st_q.ready) begin
            st_d.res_code = any_bad ? RES_PARAM_ERR : RES_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ready: 1'b0, res_valid: 1'b0, res_code: RES_OK};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.ready;
    assign res_valid = st_q.res_valid;
    assign res_code  = st_q.res_code;

endmodule

// File: rtl/spi_xfer_gate_chk.sv
module spi_xfer_gate_chk
    import spi_gate_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [FIELD_W-1:0]    cap_cs_count,
    input logic [CAP_MODE_W-1:0] cap_mode_sup,
    input logic [WORD_W-1:0]     cap_max_freq,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [FIELD_W-1:0]    req_cs,
    input logic [WORD_W-1:0]     req_freq,
    input logic                  res_valid,
    input logic [1:0]            res_code
);

    // R1
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    // R1
    no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !res_valid);

    // R1
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code == 2'd0 || res_code == 2'd1));

    // R3
    cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cs >= cap_cs_count) |=> res_code == 2'd1);

    // R9
    freq_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cap_max_freq != '0 && req_freq > cap_max_freq)
        |=> res_code == 2'd1);

    // R11
    broken_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (cap_mode_sup[1:0] == 2'b11 || cap_mode_sup[3:2] == 2'b11))
        |=> res_code == 2'd1);

endmodule

bind spi_xfer_gate spi_xfer_gate_chk u_chk (.*);

// File: tb/tb_spi_xfer_gate.sv
`timescale 1ns/1ps
module tb_spi_xfer_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cap_cs_count;
    logic        cap_cs_toggle_off;
    logic [2:0]  cap_tx_lanes, cap_rx_lanes;
    logic [31:0] cap_bpw_mask;
    logic [6:0]  cap_mode_sup;
    logic [31:0] cap_max_freq, cap_max_word_dly, cap_max_setup, cap_max_hold, cap_max_inact;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cs, req_bpw, req_cs_change, req_tx_lanes, req_rx_lanes;
    logic [4:0]  req_mode;
    logic [31:0] req_freq, req_word_dly, req_setup, req_hold, req_inact;
    logic        res_valid;
    logic [1:0]  res_code;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    spi_xfer_gate dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic baseline();
        cap_cs_count = 8'd4;     cap_cs_toggle_off = 1'b0;
        cap_tx_lanes = 3'b111;   cap_rx_lanes = 3'b111;
        cap_bpw_mask = 32'd0;    cap_mode_sup = 7'b1110000;
        cap_max_freq = 32'd1000; cap_max_word_dly = 32'd100;
        cap_max_setup = 32'd100; cap_max_hold = 32'd100; cap_max_inact = 32'd100;
        req_cs = 8'd0;  req_bpw = 8'd8; req_cs_change = 8'd0;
        req_tx_lanes = 8'd1; req_rx_lanes = 8'd1; req_mode = 5'd0;
        req_freq = 32'd500; req_word_dly = 32'd0; req_setup = 32'd0;
        req_hold = 32'd0; req_inact = 32'd0;
    endtask

    // drive the current header for one cycle; caller sets fields first
    task automatic issue(input int exp, input string tag);
        req_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected result", 1, 0);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, int'(res_code), e);
                end
            end
        end
    end

    initial begin
        #(20ns * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        baseline();
        repeat (3) @(negedge clk);
        check("R12 res_valid in reset", int'(res_valid), 0);
        check("R12 res_code in reset", int'(res_code), 0);
        check("R1 ready low in reset", int'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R12 res_valid after reset", int'(res_valid), 0);

        baseline(); issue(0, "R2 legal header");
        baseline(); req_cs = 8'd3; issue(0, "R3 last cs");
        baseline(); req_cs = 8'd4; issue(1, "R3 cs at count");
        baseline(); req_bpw = 8'd0; issue(1, "R4 bpw zero");
        baseline(); req_bpw = 8'd33; issue(1, "R4 bpw 33");
        baseline(); req_bpw = 8'd32; issue(0, "R4 bpw 32 open mask");
        baseline(); cap_bpw_mask = 32'h80; issue(0, "R4 bpw 8 in mask");
        baseline(); cap_bpw_mask = 32'h80; req_bpw = 8'd16; issue(1, "R4 bpw 16 not in mask");
        baseline(); cap_cs_toggle_off = 1'b1; req_cs_change = 8'd1; issue(1, "R5 toggle refused");
        baseline(); req_cs_change = 8'd1; issue(0, "R5 toggle allowed");
        baseline(); cap_cs_toggle_off = 1'b1; issue(0, "R5 no toggle asked");
        baseline(); req_tx_lanes = 8'd3; issue(1, "R6 tx lanes 3");
        baseline(); cap_tx_lanes = 3'b010; req_tx_lanes = 8'd4; issue(0, "R6 tx quad ok");
        baseline(); cap_tx_lanes = 3'b011; req_tx_lanes = 8'd8; issue(1, "R6 tx octal refused");
        baseline(); cap_rx_lanes = 3'b000; req_rx_lanes = 8'd2; issue(1, "R6 rx dual refused");
        baseline(); cap_tx_lanes = 3'b000; cap_rx_lanes = 3'b000; req_tx_lanes = 8'd0;
                    issue(0, "R6 lane zero single");
        baseline(); cap_mode_sup[1:0] = 2'b01; req_mode[0] = 1'b1; issue(1, "R7 phase only 0");
        baseline(); cap_mode_sup[1:0] = 2'b10; issue(1, "R7 phase only 1 req 0");
        baseline(); cap_mode_sup[1:0] = 2'b10; req_mode[0] = 1'b1; issue(0, "R7 phase only 1 req 1");
        baseline(); cap_mode_sup[3:2] = 2'b01; req_mode[1] = 1'b1; issue(1, "R7 polarity only 0");
        baseline(); cap_mode_sup[4] = 1'b0; req_mode[2] = 1'b1; issue(1, "R8 cs high refused");
        baseline(); req_mode[2] = 1'b1; issue(0, "R8 cs high ok");
        baseline(); cap_mode_sup[5] = 1'b0; req_mode[3] = 1'b1; issue(1, "R8 lsb refused");
        baseline(); cap_mode_sup[6] = 1'b0; req_mode[4] = 1'b1; issue(1, "R8 loop refused");
        baseline(); req_freq = 32'd1000; issue(0, "R9 freq at max");
        baseline(); req_freq = 32'd1001; issue(1, "R9 freq above max");
        baseline(); cap_max_freq = 32'd0; req_freq = 32'hFFFF_FFFF; issue(0, "R9 unlimited");
        baseline(); cap_max_setup = 32'd0; req_setup = 32'd1; issue(1, "R10 setup unsupported");
        baseline(); cap_max_hold = 32'd50; req_hold = 32'd50; issue(0, "R10 hold at max");
        baseline(); cap_max_hold = 32'd50; req_hold = 32'd51; issue(1, "R10 hold above max");
        baseline(); cap_max_inact = 32'd0; issue(0, "R10 inactive zero ok");
        baseline(); cap_max_word_dly = 32'd10; req_word_dly = 32'd11; issue(1, "R10 word delay above");
        baseline(); cap_mode_sup[1:0] = 2'b11; issue(1, "R11 broken phase cap");
        baseline(); cap_mode_sup[3:2] = 2'b11; issue(1, "R11 broken polarity cap");
        baseline(); issue(0, "R2 final legal");
        idle(2);
        check("R1 idle no result", int'(res_valid), 0);
        check("R1 all results seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule